// File: doc/BRIEF.md
# Real-Time Clock Register File

This block is the software-visible register file of a real-time clock. A host first loads an address register, then reads or writes a byte through a single data port. Seven timekeeping fields sit in this space: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-second tick input advances them. A control bit chooses whether time values cross the data port as packed BCD or as plain binary. A few status addresses return fixed or synthesized values, one of which is an update flag that clears when it is read. All other addresses reach a 64-byte general-purpose store.

Time is held internally in binary. Conversion to and from BCD takes place only at the data port, so the carry chain stays a set of plain binary comparisons. The address register can optionally be folded to its low six bits, so that high addresses alias onto the low map.

Top module: `rtc_regfile`

## Requirements
- R1: Writing with `addr_we` latches `wdata` as the register address. A `data_rd` pulse updates `rdata` at the following clock edge, and `rdata` holds its value until the next `data_rd`.
- R2: The time fields sit at these effective addresses: seconds 0, minutes 2, hours 4, day of week 6, day of month 7, month 8, year 9. A data write to any of them loads that field. After reset the time reads 00:00:00, day of week 1, date 1, month 1, year 0.
- R3: While bit 2 of the control register at address 11 is 0, time reads and time writes use BCD, with tens in bits 7:4 and units in bits 3:0. While that bit is 1, they use binary. Day of week is always plain binary.
- R4: A read of address 10 returns 0x20 OR the low nibble last written there. The reset nibble is 0.
- R5: A read of address 11 returns its stored bit 2 OR 0x02. The other written bits are dropped.
- R6: Each tick sets an update flag. A read of address 12 returns 0x10 when the flag is set and 0x00 when it is clear, then clears it. A tick in the same cycle as that read leaves the flag set, and the read still returns the old flag value.
- R7: A read of address 13 always returns 0x80. Data writes to addresses 12 and 13 change nothing.
- R8: When `wrap6` is 1, the effective address is the address register AND 0x3F. When `wrap6` is 0, the effective address is the full 8-bit address.
- R9: On a tick, seconds count 0 to 59, minutes advance when seconds wrap and count 0 to 59, and hours advance when minutes wrap and count 0 to 23.
- R10: When hours wrap, the date advances. The date returns to 1 after the month's last day: 31 for months 1,3,5,7,8,10,12, 30 for months 4,6,9,11, and for February 29 when year mod 4 is 0 and 28 otherwise. The month wraps from 12 to 1 and increments the year, which wraps from 99 to 0.
- R11: Day of week advances with each date change and goes from 7 back to 1.
- R12: Every other effective address stores the written byte in a 64-entry memory indexed by effective address bits 5:0, and reads return it. This includes 1, 3, 5, 14 to 63, and 64 to 255 with `wrap6` at 0.
- R13: A data write to a time field in the same cycle as a tick takes priority. No field advances in that cycle, and the update flag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrap6 | input | 1 | Fold the address to 6 bits |
| tick_1s | input | 1 | One-cycle pulse, once per second |
| addr_we | input | 1 | Load the address register from `wdata` |
| data_we | input | 1 | Write `wdata` to the addressed register |
| data_rd | input | 1 | Read the addressed register into `rdata` |
| wdata | input | 8 | Address or data byte |
| rdata | output | 8 | Registered read data |

## Verification
Two pairs of functions can share a cycle. A tick can coincide with the read that clears the update flag, and a tick can coincide with a host write to a time field. The bench raises `tick_1s` on the same falling edge as `data_rd` on address 12. It expects the read to return the flag as it stood before that edge, and a second read to show the flag still set. It also raises a tick together with a seconds write and expects exactly the written value afterwards, with no increment and with the update flag reported as set. Rollover is checked by sweeping every month in a leap and a non-leap year through midnight, and by a long run checked after every tick in both data modes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int A_SEC  = 0;
  localparam int A_MIN  = 2;
  localparam int A_HR   = 4;
  localparam int A_DOW  = 6;
  localparam int A_DATE = 7;
  localparam int A_MON  = 8;
  localparam int A_YR   = 9;
  localparam int A_CTLA = 10;
  localparam int A_CTLB = 11;
  localparam int A_FLAG = 12;
  localparam int A_VALID = 13;

  localparam int CTLB_BIN_BIT = 2;

  typedef enum logic [2:0] {
    F_SEC, F_MIN, F_HR, F_DOW, F_DATE, F_MON, F_YR
  } fld_e;

  typedef enum logic [2:0] {
    K_TIME, K_CTLA, K_CTLB, K_FLAG, K_VALID, K_RAM
  } kind_e;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [6:0] hr;
    logic [2:0] dow;
    logic [4:0] date;
    logic [3:0] mon;
    logic [6:0] yr;
  } tod_t;

  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    logic [7:0] t;
    t = {1'b0, v} / 8'd10;
    return (t << 4) + ({1'b0, v} - t * 8'd10);
  endfunction

  function automatic logic [6:0] from_bcd(input logic [7:0] b);
    return ({3'b000, b[7:4]} * 7'd10) + {3'b000, b[3:0]};
  endfunction

  function automatic logic [4:0] month_len(input logic [3:0] m, input logic leap);
    case (m)
      4'd2:                      return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
#(
  parameter int SEC_MAX = 59,
  parameter int MIN_MAX = 59,
  parameter int HR_MAX  = 23,
  parameter int DOW_MAX = 7,
  parameter int MON_MAX = 12,
  parameter int YR_MAX  = 99
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       ld_en,
  input  fld_e       ld_fld,
  input  logic [6:0] ld_val,
  output tod_t       tod_q
);

  logic       sec_end, min_end, hr_end, day_end, mon_end;
  logic [4:0] mlen;

  always_comb begin
    mlen    = month_len(tod_q.mon, tod_q.yr[1:0] == 2'b00);
    sec_end = tod_q.sec >= 7'(SEC_MAX);
    min_end = sec_end && (tod_q.min >= 7'(MIN_MAX));
    hr_end  = min_end && (tod_q.hr >= 7'(HR_MAX));
    day_end = hr_end && (tod_q.date >= mlen);
    mon_end = day_end && (tod_q.mon >= 4'(MON_MAX));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tod_q.sec  <= '0;
      tod_q.min  <= '0;
      tod_q.hr   <= '0;
      tod_q.dow  <= 3'd1;
      tod_q.date <= 5'd1;
      tod_q.mon  <= 4'd1;
      tod_q.yr   <= '0;
    end else if (ld_en) begin
      case (ld_fld)
        F_SEC:   tod_q.sec  <= ld_val;
        F_MIN:   tod_q.min  <= ld_val;
        F_HR:    tod_q.hr   <= ld_val;
        F_DOW:   tod_q.dow  <= ld_val[2:0];
        F_DATE:  tod_q.date <= ld_val[4:0];
        F_MON:   tod_q.mon  <= ld_val[3:0];
        default: tod_q.yr   <= ld_val;
      endcase
    end else if (tick) begin
      tod_q.sec <= sec_end ? 7'd0 : tod_q.sec + 7'd1;
      if (sec_end) tod_q.min <= min_end ? 7'd0 : tod_q.min + 7'd1;
      if (min_end) tod_q.hr  <= hr_end  ? 7'd0 : tod_q.hr + 7'd1;
      if (hr_end) begin
        tod_q.dow  <= (tod_q.dow >= 3'(DOW_MAX)) ? 3'd1 : tod_q.dow + 3'd1;
        tod_q.date <= day_end ? 5'd1 : tod_q.date + 5'd1;
      end
      if (day_end) tod_q.mon <= mon_end ? 4'd1 : tod_q.mon + 4'd1;
      if (mon_end) tod_q.yr  <= (tod_q.yr >= 7'(YR_MAX)) ? 7'd0 : tod_q.yr + 7'd1;
    end
  end

  assert_sec_step_R9: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_en && tod_q.sec < 7'(SEC_MAX)) |=> tod_q.sec == $past(tod_q.sec) + 7'd1);

  assert_date_restart_R10: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_en && day_end) |=> tod_q.date == 5'd1);

  assert_dow_wrap_R11: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_en && hr_end && tod_q.dow == 3'(DOW_MAX)) |=> tod_q.dow == 3'd1);

  assert_load_wins_R13: assert property (@(posedge clk) disable iff (rst)
    (ld_en && tick && ld_fld == F_SEC) |=> tod_q.sec == $past(ld_val));

endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl #(
  parameter int NIB_W   = 4,
  parameter int BIN_BIT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_a,
  input  logic             wr_b,
  input  logic             rd_flag,
  input  logic [7:0]       wdata,
  output logic [NIB_W-1:0] nib_q,
  output logic             bin_q,
  output logic             upd_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      nib_q <= '0;
      bin_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      if (wr_a) nib_q <= wdata[NIB_W-1:0];
      if (wr_b) bin_q <= wdata[BIN_BIT];
      upd_q <= tick | (upd_q & ~rd_flag);
    end
  end

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (rst)
    tick |=> upd_q);

  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_flag && !tick) |=> !upd_q);

endmodule

// File: rtl/rtc_nvram.sv
module rtc_nvram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata_q
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata_q <= mem[raddr];
  end

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int RAM_DEPTH = 64,
  parameter int FOLD_W    = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wrap6,
  input  logic       tick_1s,
  input  logic       addr_we,
  input  logic       data_we,
  input  logic       data_rd,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);

  localparam int IDX_W = $clog2(RAM_DEPTH);
  localparam logic [ADDR_W-1:0] FOLD_MASK = ADDR_W'((1 << FOLD_W) - 1);

  logic [ADDR_W-1:0] addr_q, eff;
  kind_e             kind;
  fld_e              fld;
  tod_t              tod;
  logic [3:0]        nib;
  logic              bin_mode, upd;
  logic [6:0]        tval;
  logic [7:0]        rd_val, reg_q, ram_q;
  logic              from_ram_q;
  logic              ld_en, wr_a, wr_b, rd_flag, ram_we;
  logic [6:0]        ld_val;

  always_ff @(posedge clk) begin
    if (rst)          addr_q <= '0;
    else if (addr_we) addr_q <= wdata[ADDR_W-1:0];
  end

  always_comb begin
    eff  = wrap6 ? (addr_q & FOLD_MASK) : addr_q;
    kind = K_TIME;
    fld  = F_SEC;
    case (eff)
      ADDR_W'(A_SEC):   fld = F_SEC;
      ADDR_W'(A_MIN):   fld = F_MIN;
      ADDR_W'(A_HR):    fld = F_HR;
      ADDR_W'(A_DOW):   fld = F_DOW;
      ADDR_W'(A_DATE):  fld = F_DATE;
      ADDR_W'(A_MON):   fld = F_MON;
      ADDR_W'(A_YR):    fld = F_YR;
      ADDR_W'(A_CTLA):  kind = K_CTLA;
      ADDR_W'(A_CTLB):  kind = K_CTLB;
      ADDR_W'(A_FLAG):  kind = K_FLAG;
      ADDR_W'(A_VALID): kind = K_VALID;
      default:          kind = K_RAM;
    endcase
  end

  always_comb begin
    ld_en   = data_we && kind == K_TIME;
    wr_a    = data_we && kind == K_CTLA;
    wr_b    = data_we && kind == K_CTLB;
    ram_we  = data_we && kind == K_RAM;
    rd_flag = data_rd && kind == K_FLAG;
    ld_val  = bin_mode ? wdata[6:0] : from_bcd(wdata);
  end

  rtc_timekeeper u_time (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick_1s),
    .ld_en  (ld_en),
    .ld_fld (fld),
    .ld_val (ld_val),
    .tod_q  (tod)
  );

  rtc_ctrl #(.NIB_W(4), .BIN_BIT(CTLB_BIN_BIT)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_1s),
    .wr_a    (wr_a),
    .wr_b    (wr_b),
    .rd_flag (rd_flag),
    .wdata   (wdata),
    .nib_q   (nib),
    .bin_q   (bin_mode),
    .upd_q   (upd)
  );

  rtc_nvram #(.DEPTH(RAM_DEPTH), .WIDTH(8)) u_ram (
    .clk     (clk),
    .we      (ram_we),
    .waddr   (eff[IDX_W-1:0]),
    .wdata   (wdata),
    .re      (data_rd),
    .raddr   (eff[IDX_W-1:0]),
    .rdata_q (ram_q)
  );

  always_comb begin
    case (fld)
      F_SEC:   tval = tod.sec;
      F_MIN:   tval = tod.min;
      F_HR:    tval = tod.hr;
      F_DOW:   tval = {4'b0000, tod.dow};
      F_DATE:  tval = {2'b00, tod.date};
      F_MON:   tval = {3'b000, tod.mon};
      default: tval = tod.yr;
    endcase
    case (kind)
      K_TIME:  rd_val = (bin_mode || fld == F_DOW) ? {1'b0, tval} : to_bcd(tval);
      K_CTLA:  rd_val = {4'h2, nib};
      K_CTLB:  rd_val = {5'b00000, bin_mode, 2'b10};
      K_FLAG:  rd_val = upd ? 8'h10 : 8'h00;
      K_VALID: rd_val = 8'h80;
      default: rd_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q      <= '0;
      from_ram_q <= 1'b0;
    end else if (data_rd) begin
      reg_q      <= rd_val;
      from_ram_q <= kind == K_RAM;
    end
  end

  assign rdata = from_ram_q ? ram_q : reg_q;

  assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !data_rd |=> $stable(rdata));

  assert_ctla_prefix_R4: assert property (@(posedge clk) disable iff (rst)
    (data_rd && eff == ADDR_W'(A_CTLA)) |=> rdata[7:4] == 4'h2);

  assert_valid_const_R7: assert property (@(posedge clk) disable iff (rst)
    (data_rd && eff == ADDR_W'(A_VALID)) |=> rdata == 8'h80);

  assert_ctlb_24h_R5: assert property (@(posedge clk) disable iff (rst)
    (data_rd && eff == ADDR_W'(A_CTLB)) |=> rdata[1] && !rdata[0]);

endmodule

// File: tb/rtc_regfile_bench.sv
module rtc_regfile_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrap6 = 1'b0, tick_1s = 1'b0;
  logic       addr_we = 1'b0, data_we = 1'b0, data_rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int checks = 0, errors = 0, cycles = 0;
  int msec, mmin, mhr, mdow, mdate, mmon, myr;
  bit dm = 0;
  logic [7:0] v;

  rtc_regfile u_rtc_regfile (
    .clk(clk), .rst(rst), .wrap6(wrap6), .tick_1s(tick_1s),
    .addr_we(addr_we), .data_we(data_we), .data_rd(data_rd),
    .wdata(wdata), .rdata(rdata)
  );

  always #10 clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  function automatic int bcd(int x);
    return (x / 10) * 16 + (x % 10);
  endfunction

  function automatic int mlen(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic int enc(int a, int x);
    if (a == 6 || dm) return x;
    return bcd(x);
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic set_addr(int a);
    @(negedge clk); addr_we = 1'b1; wdata = 8'(a);
    @(negedge clk); addr_we = 1'b0;
  endtask

  task automatic wr(int a, int d);
    set_addr(a);
    data_we = 1'b1; wdata = 8'(d);
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [7:0] r);
    set_addr(a);
    data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
    r = rdata;
  endtask

  task automatic model_step();
    msec++;
    if (msec == 60) begin
      msec = 0; mmin++;
      if (mmin == 60) begin
        mmin = 0; mhr++;
        if (mhr == 24) begin
          mhr = 0;
          mdow = (mdow == 7) ? 1 : mdow + 1;
          if (mdate >= mlen(mmon, myr)) begin
            mdate = 1;
            if (mmon >= 12) begin mmon = 1; myr = (myr + 1) % 100; end
            else mmon++;
          end else mdate++;
        end
      end
    end
  endtask

  task automatic do_tick();
    @(negedge clk); tick_1s = 1'b1;
    @(negedge clk); tick_1s = 1'b0;
    model_step();
  endtask

  task automatic load_all(int s, int mi, int h, int dw, int dt, int mo, int y);
    msec = s; mmin = mi; mhr = h; mdow = dw; mdate = dt; mmon = mo; myr = y;
    wr(0, enc(0, s)); wr(2, enc(2, mi)); wr(4, enc(4, h)); wr(6, dw);
    wr(7, enc(7, dt)); wr(8, enc(8, mo)); wr(9, enc(9, y));
  endtask

  task automatic check_all(string tag);
    logic [7:0] r;
    rd(0, r); check({tag, " sec R9"},  r, 8'(enc(0, msec)));
    rd(2, r); check({tag, " min R9"},  r, 8'(enc(2, mmin)));
    rd(4, r); check({tag, " hr R9"},   r, 8'(enc(4, mhr)));
    rd(6, r); check({tag, " dow R11"}, r, 8'(mdow));
    rd(7, r); check({tag, " date R10"}, r, 8'(enc(7, mdate)));
    rd(8, r); check({tag, " mon R10"}, r, 8'(enc(8, mmon)));
    rd(9, r); check({tag, " yr R10"},  r, 8'(enc(9, myr)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    msec = 0; mmin = 0; mhr = 0; mdow = 1; mdate = 1; mmon = 1; myr = 0;

    // R2 reset state, R4/R5/R6/R7 reset reads
    check_all("reset R2");
    rd(10, v); check("reset ctla R4", v, 8'h20);
    rd(11, v); check("reset ctlb R5", v, 8'h02);
    rd(12, v); check("reset flag R6", v, 8'h00);
    rd(13, v); check("valid R7", v, 8'h80);

    // R1: rdata holds between reads
    repeat (3) @(negedge clk);
    check("hold R1", rdata, 8'h80);

    // R4 / R5 control registers
    wr(10, 8'hA7); rd(10, v); check("ctla nibble R4", v, 8'h27);
    wr(11, 8'hFF); rd(11, v); check("ctlb bin R5", v, 8'h06);
    wr(11, 8'hFB); rd(11, v); check("ctlb drop R5", v, 8'h02);

    // R7: writes to 12/13 ignored
    wr(13, 8'h00); rd(13, v); check("valid after write R7", v, 8'h80);
    wr(12, 8'hFF); rd(12, v); check("flag after write R7", v, 8'h00);

    // R12: memory sweep over every general-purpose address
    for (int a = 1; a < 64; a++)
      if (!(a == 2 || a == 4 || (a >= 6 && a <= 13))) wr(a, a ^ 8'h5A);
    for (int a = 1; a < 64; a++)
      if (!(a == 2 || a == 4 || (a >= 6 && a <= 13))) begin
        rd(a, v); check("ram R12", v, 8'(a ^ 8'h5A));
      end

    // R8/R12: high addresses alias into memory when not folded
    wr(64 + 20, 8'hC3); rd(20, v); check("alias high R12", v, 8'hC3);
    rd(128 + 20, v); check("alias read R8", v, 8'hC3);
    wr(64, 8'h99); rd(0, v); check("seconds untouched R8", v, 8'h00);
    rd(64, v); check("ram0 R12", v, 8'h99);
    wrap6 = 1'b1;
    rd(64 + 13, v); check("fold valid R8", v, 8'h80);
    wr(64 + 10, 8'h05); rd(10, v); check("fold ctla R8", v, 8'h25);
    rd(192 + 20, v); check("fold ram R8", v, 8'hC3);
    wrap6 = 1'b0;

    // R6 update flag
    do_tick();
    rd(12, v); check("flag set R6", v, 8'h10);
    rd(12, v); check("flag cleared R6", v, 8'h00);
    // tick coinciding with flag read: flag clear before
    set_addr(12);
    data_rd = 1'b1; tick_1s = 1'b1;
    @(negedge clk); data_rd = 1'b0; tick_1s = 1'b0; model_step();
    check("collide old clear R6", rdata, 8'h00);
    // flag now set; collide again
    set_addr(12);
    data_rd = 1'b1; tick_1s = 1'b1;
    @(negedge clk); data_rd = 1'b0; tick_1s = 1'b0; model_step();
    check("collide old set R6", rdata, 8'h10);
    rd(12, v); check("collide keeps flag R6", v, 8'h10);

    // R13: write and tick same cycle
    set_addr(0);
    data_we = 1'b1; wdata = 8'h30; tick_1s = 1'b1;
    @(negedge clk); data_we = 1'b0; tick_1s = 1'b0;
    msec = 30;
    rd(0, v); check("write wins R13", v, 8'h30);
    rd(12, v); check("flag with write R13", v, 8'h10);
    check_all("after collide R13");

    // R3 BCD: write in BCD, read back
    load_all(45, 37, 19, 3, 21, 6, 88);
    check_all("bcd load R3");

    // R10 month-end sweep, leap and non-leap years, BCD mode
    for (int y = 3; y <= 4; y++)
      for (int m = 1; m <= 12; m++) begin
        load_all(59, 59, 23, (m % 7) + 1, mlen(m, y), m, y);
        do_tick();
        check_all("month end R10");
      end
    load_all(58, 59, 23, 7, 31, 12, 99);
    for (int k = 0; k < 3; k++) begin do_tick(); check_all("year wrap R10"); end
    load_all(59, 59, 23, 2, 28, 2, 5);
    do_tick(); check_all("feb nonleap R10");

    // R3 binary mode, long run through minute and hour carries
    wr(11, 8'h04); dm = 1;
    rd(11, v); check("bin mode R5", v, 8'h06);
    load_all(50, 58, 22, 6, 30, 4, 23);
    for (int k = 0; k < 160; k++) begin do_tick(); check_all("bin run R9"); end
    load_all(55, 59, 23, 7, 29, 2, 24);
    for (int k = 0; k < 8; k++) begin do_tick(); check_all("bin leap R10"); end

    // back to BCD, run
    wr(11, 8'h00); dm = 0;
    load_all(40, 59, 9, 4, 15, 10, 47);
    for (int k = 0; k < 90; k++) begin do_tick(); check_all("bcd run R3"); end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule